// File: doc/BRIEF.md
# Byte-Wide SAR Converter Sequencer

This block sits on the host side of a 14-bit successive-approximation converter that has its own conversion clock. It drives three control lines: an active-low chip select, a read/convert select and a high-byte select. It watches the converter's active-low end-of-conversion flag. The result comes back over an 8-bit parallel bus that only the converter drives. A sample request starts a full sequence:

1. A chip-select pulse with read/convert low starts acquisition.
2. The sequencer times an acquisition window.
3. A second chip-select pulse starts the conversion. The read/convert level at that second edge tells the converter whether to stay in standby or shut down afterwards.
4. The sequencer waits for end-of-conversion, with a timeout.
5. Two byte reads follow, the high byte first.

A shutdown leaves the converter's reference off, so the next acquisition window is stretched to the long wake-up time. The same applies after reset and after a timeout, when the converter state is unknown. The finished 14-bit two's-complement word is presented with a one-cycle strobe. All durations are cycle counts given as parameters.

Top module: `adc_byte_host`

## Requirements
- R1: Out of reset and whenever not busy, chip select is high, read/convert is low, high-byte select is low, and busy, result strobe and error are low.
- R2: A request while idle causes a chip-select falling edge with read/convert low in the cycle busy rises. Chip select stays low for CS_W_CYC cycles, then goes high.
- R3: When the previous conversion ended in standby, exactly CS_W_CYC + ACQ_CYC cycles separate the first and second chip-select falling edges.
- R4: Read/convert at the second chip-select falling edge is 1 if shutdown was requested (mode input high) and 0 for standby. Read/convert never changes in a cycle where chip select falls.
- R5: After a conversion that ended in shutdown, after reset and after a timeout, the two falling edges are exactly CS_W_CYC + WAKE_CYC cycles apart.
- R6: Once end-of-conversion is seen low, chip select falls with read/convert high. The high-byte select is high for DV_CYC cycles, then low for DV_CYC cycles, all with chip select low. High-byte select is never high unless chip select is low and read/convert is high.
- R7: The result is the low 6 bits of the high byte (bit 5 becomes result bit 13) followed by the 8 bits of the low byte. The top 2 bits of the high byte are ignored. The strobe is high for one cycle, CS_W_CYC cycles after chip select rises at the end of the read.
- R8: If end-of-conversion is not low within EOC_TO_CYC cycles after chip select rises following the second edge, the error output pulses for one cycle and the block returns to idle with no result strobe. The error pulse comes CS_W_CYC + EOC_TO_CYC cycles after the second falling edge.
- R9: Busy is high from the cycle after an accepted request until the cycle that carries the result strobe or the error pulse, in which it is already low. Requests while busy start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Sample request, taken only when idle |
| shdn_i | input | 1 | Post-conversion mode for this request: 1 shutdown, 0 standby |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rc_o | output | 1 | Converter read/convert select |
| adc_hben_o | output | 1 | Converter high-byte select |
| adc_eoc_n_i | input | 1 | Converter end-of-conversion, active low, asynchronous |
| adc_data_i | input | 8 | Converter byte bus |
| result_o | output | 14 | Last result, two's complement |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| busy_o | output | 1 | Sequence in progress |
| timeout_err_o | output | 1 | One-cycle pulse when end-of-conversion times out |

## Verification
A behavioural converter in the bench decodes the chip-select edges, measures the acquisition window, records the mode level and drives the bus. The bench walks a table of codes: zero, the extreme positive and negative values, minus one and alternating bit patterns. These tell apart a byte swap, a wrong sign bit and a failure to mask the two spare high-byte bits. The table alternates standby and shutdown requests, so each window length tells whether the wake-up stretch follows the previous conversion's mode rather than the current one. Directed cases cover a request during a busy sequence and a converter that never signals completion, with the window that follows that timeout.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
    localparam int RES_W  = 14;
    localparam int BYTE_W = 8;
    localparam int HI_W   = RES_W - BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ_LO,
        ST_ACQ_HI,
        ST_CNV_LO,
        ST_CNV_WAIT,
        ST_RD_HI,
        ST_RD_LO,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic              cs_n;
        logic              rc;
        logic              hben;
        logic              busy;
        logic              valid;
        logic              err;
        logic              mode;
        logic              wake;
        logic [HI_W-1:0]   hi;
        logic [RES_W-1:0]  result;
    } seq_ctl_s;
endpackage

// File: rtl/adc_host_sync.sv
module adc_host_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_host_timer.sv
module adc_host_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_host_assemble.sv
module adc_host_assemble #(
    parameter int RES_W     = 14,
    parameter int BYTE_W    = 8,
    parameter bit OFFSET_IN = 1'b0
) (
    input  logic [RES_W-BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0]       lo_i,
    output logic [RES_W-1:0]        word_o
);
    logic [RES_W-1:0] raw;
    assign raw = {hi_i, lo_i};

    generate
        if (OFFSET_IN) begin : g_offset
            assign word_o = {~raw[RES_W-1], raw[RES_W-2:0]};
        end else begin : g_twos
            assign word_o = raw;
        end
    endgenerate
endmodule

// File: rtl/adc_byte_host.sv
module adc_byte_host
    import adc_host_pkg::*;
#(
    parameter int ACQ_CYC     = 100,
    parameter int CS_W_CYC    = 4,
    parameter int DV_CYC      = 3,
    parameter int EOC_TO_CYC  = 600,
    parameter int WAKE_CYC    = 1_200_000,
    parameter int SYNC_STAGES = 2,
    parameter bit OFFSET_IN   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              shdn_i,
    output logic              adc_cs_n_o,
    output logic              adc_rc_o,
    output logic              adc_hben_o,
    input  logic              adc_eoc_n_i,
    input  logic [BYTE_W-1:0] adc_data_i,
    output logic [RES_W-1:0]  result_o,
    output logic              result_valid_o,
    output logic              busy_o,
    output logic              timeout_err_o
);
    localparam int M1   = (ACQ_CYC > CS_W_CYC) ? ACQ_CYC : CS_W_CYC;
    localparam int M2   = (DV_CYC > EOC_TO_CYC) ? DV_CYC : EOC_TO_CYC;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M3 > WAKE_CYC) ? M3 : WAKE_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    localparam logic [TW-1:0] L_CSW  = TW'(CS_W_CYC - 1);
    localparam logic [TW-1:0] L_ACQ  = TW'(ACQ_CYC - 1);
    localparam logic [TW-1:0] L_WAKE = TW'(WAKE_CYC - 1);
    localparam logic [TW-1:0] L_TO   = TW'(EOC_TO_CYC - 1);
    localparam logic [TW-1:0] L_DV   = TW'(DV_CYC - 1);

    seq_ctl_s        q, d;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_done;
    logic            eoc_n_s;
    logic [RES_W-1:0] word;

    adc_host_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(adc_eoc_n_i), .sync_o(eoc_n_s)
    );

    adc_host_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_done)
    );

    adc_host_assemble #(.RES_W(RES_W), .BYTE_W(BYTE_W), .OFFSET_IN(OFFSET_IN)) u_asm (
        .hi_i(q.hi), .lo_i(adc_data_i), .word_o(word)
    );

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        d.err    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;

        unique case (q.state)
            ST_IDLE: if (req_i) begin
                d.state  = ST_ACQ_LO;
                d.mode   = shdn_i;
                tmr_load = 1'b1;
                tmr_val  = L_CSW;
            end
            ST_ACQ_LO: if (tmr_done) begin
                d.state  = ST_ACQ_HI;
                tmr_load = 1'b1;
                tmr_val  = q.wake ? L_WAKE : L_ACQ;
            end
            ST_ACQ_HI: if (tmr_done) begin
                d.state  = ST_CNV_LO;
                tmr_load = 1'b1;
                tmr_val  = L_CSW;
            end
            ST_CNV_LO: if (tmr_done) begin
                d.state  = ST_CNV_WAIT;
                tmr_load = 1'b1;
                tmr_val  = L_TO;
            end
            ST_CNV_WAIT: begin
                if (!eoc_n_s) begin
                    d.state  = ST_RD_HI;
                    tmr_load = 1'b1;
                    tmr_val  = L_DV;
                end else if (tmr_done) begin
                    d.state = ST_IDLE;
                    d.err   = 1'b1;
                    d.wake  = 1'b1;
                end
            end
            ST_RD_HI: if (tmr_done) begin
                d.state  = ST_RD_LO;
                d.hi     = adc_data_i[HI_W-1:0];
                tmr_load = 1'b1;
                tmr_val  = L_DV;
            end
            ST_RD_LO: if (tmr_done) begin
                d.state  = ST_GAP;
                d.result = word;
                d.wake   = q.mode;
                tmr_load = 1'b1;
                tmr_val  = L_CSW;
            end
            ST_GAP: if (tmr_done) begin
                d.state = ST_IDLE;
                d.valid = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase

        d.cs_n = !(d.state inside {ST_ACQ_LO, ST_CNV_LO, ST_RD_HI, ST_RD_LO});
        d.hben = (d.state == ST_RD_HI);
        d.busy = (d.state != ST_IDLE);
        if (d.state inside {ST_ACQ_HI, ST_CNV_LO})
            d.rc = d.mode;
        else
            d.rc = (d.state inside {ST_CNV_WAIT, ST_RD_HI, ST_RD_LO, ST_GAP});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= ST_IDLE;
            q.cs_n   <= 1'b1;
            q.wake   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign adc_cs_n_o     = q.cs_n;
    assign adc_rc_o       = q.rc;
    assign adc_hben_o     = q.hben;
    assign result_o       = q.result;
    assign result_valid_o = q.valid;
    assign busy_o         = q.busy;
    assign timeout_err_o  = q.err;
endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rc,
    input logic hben,
    input logic busy,
    input logic valid,
    input logic err
);
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !hben)); // R1
    AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!cs_n && !rc)); // R2
    AST_RC_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $stable(rc)); // R4
    AST_HBEN_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        hben |-> (!cs_n && rc)); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R7
    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !valid); // R8
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R8
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (valid || err)); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid || err) |-> !busy); // R9
endmodule

bind adc_byte_host adc_host_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (adc_cs_n_o),
    .rc   (adc_rc_o),
    .hben (adc_hben_o),
    .busy (busy_o),
    .valid(result_valid_o),
    .err  (timeout_err_o)
);

// File: tb/adc_byte_host_test.sv
module adc_byte_host_test;
    localparam int ACQ  = 6;
    localparam int CSW  = 2;
    localparam int DV   = 2;
    localparam int TO   = 40;
    localparam int WAKE = 25;
    localparam int CONV = 12;

    typedef struct packed {
        logic        shdn;
        logic [13:0] code;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 14'h0000}, '{1'b1, 14'h1FFF}, '{1'b0, 14'h2000}, '{1'b0, 14'h3FFF},
        '{1'b1, 14'h1555}, '{1'b1, 14'h2AAA}, '{1'b0, 14'h00FF}, '{1'b0, 14'h3F00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        shdn = 1'b0;
    logic        cs_n, rc, hben, valid, busy, err;
    logic [13:0] result;
    wire  [7:0]  adc_bus;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_err = 0;

    // behavioural converter
    logic        m_eoc_n = 1'b1;
    logic        m_drive = 1'b0;
    logic [7:0]  m_byte = 8'h00;
    logic        m_cs_prev = 1'b1;
    int          m_phase = 0;
    logic        m_mode = 1'b0;
    int          m_first = 0, m_second = 0, m_win = 0, m_cnt = 0;
    int          m_hi = 0, m_lo = 0, m_rise = 0, m_starts = 0;
    logic [13:0] m_code = 14'h0;
    logic        m_eoc_en = 1'b1;

    assign adc_bus = m_drive ? m_byte : 8'hzz;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_byte_host #(
        .ACQ_CYC(ACQ), .CS_W_CYC(CSW), .DV_CYC(DV), .EOC_TO_CYC(TO), .WAKE_CYC(WAKE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .shdn_i(shdn),
        .adc_cs_n_o(cs_n), .adc_rc_o(rc), .adc_hben_o(hben),
        .adc_eoc_n_i(m_eoc_n), .adc_data_i(adc_bus),
        .result_o(result), .result_valid_o(valid), .busy_o(busy),
        .timeout_err_o(err)
    );

    always @(negedge clk) begin
        if (m_cs_prev && !cs_n) begin
            if (m_phase == 0 || (m_phase == 2 && !rc && m_eoc_n)) begin
                if (!rc) begin
                    m_phase  = 1;
                    m_first  = cyc;
                    m_starts = m_starts + 1;
                end
            end else if (m_phase == 1) begin
                m_phase  = 2;
                m_mode   = rc;
                m_win    = cyc - m_first;
                m_second = cyc;
                m_cnt    = CONV;
            end else if (m_phase == 2 && rc && !m_eoc_n) begin
                m_phase = 3;
                m_hi    = 0;
                m_lo    = 0;
            end
        end
        if (!m_cs_prev && cs_n && m_phase == 3) begin
            m_phase = 0;
            m_eoc_n = 1'b1;
            m_rise  = cyc;
        end
        if (m_phase == 2 && m_eoc_en) begin
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            else           m_eoc_n = 1'b0;
        end
        if (m_phase == 3 && !cs_n) begin
            m_drive = 1'b1;
            m_byte  = hben ? {2'b10, m_code[13:8]} : m_code[7:0];
            if (hben) m_hi = m_hi + 1;
            else      m_lo = m_lo + 1;
        end else begin
            m_drive = 1'b0;
        end
        m_cs_prev = cs_n;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            finish_run();
        end
    end

    // pulse a request, check busy rises, wait for strobe or error
    task automatic sample(input logic mode, output int done_cyc);
        @(negedge clk);
        req  = 1'b1;
        shdn = mode;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R9 busy after request", int'(busy), 1);
        for (int k = 0; k < 5000; k++) begin
            if (valid || err) break;
            @(negedge clk);
        end
        done_cyc = cyc;
    endtask

    initial begin
        int  t;
        int  s0;
        bit  prev_shut;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state: {cs_n, rc, hben, busy, valid, err} = 6'b100000
        check({cs_n, rc, hben, busy, valid, err} == 6'b100000, "R1 reset lines",
              int'({cs_n, rc, hben, busy, valid, err}), 32);
        prev_shut = 1'b1;

        for (int i = 0; i < 8; i++) begin
            m_code = VECS[i].code;
            sample(VECS[i].shdn, t);
            check(valid == 1'b1 && err == 1'b0, "R7 strobe", int'(valid), 1);
            check(result == VECS[i].code, "R7 result", int'(result), int'(VECS[i].code));
            if (prev_shut)
                check(m_win == CSW + WAKE, "R5 wake window", m_win, CSW + WAKE);
            else
                check(m_win == CSW + ACQ, "R3 acquisition window", m_win, CSW + ACQ);
            check(m_mode == VECS[i].shdn, "R4 mode level", int'(m_mode), int'(VECS[i].shdn));
            check(m_hi == DV && m_lo == DV, "R6 byte read lengths", m_hi * 100 + m_lo, DV * 101);
            check(t - m_rise == CSW, "R7 strobe delay", t - m_rise, CSW);
            check(busy == 1'b0, "R9 busy low at strobe", int'(busy), 0);
            @(negedge clk);
            check(valid == 1'b0, "R7 single-cycle strobe", int'(valid), 0);
            prev_shut = VECS[i].shdn;
        end

        // R9: request during a sequence is ignored
        s0 = m_starts;
        m_code = 14'h0123;
        @(negedge clk);
        req = 1'b1; shdn = 1'b0;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        req = 1'b1; shdn = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            if (valid || err) break;
            @(negedge clk);
        end
        check(result == 14'h0123, "R9 result unaffected", int'(result), 'h123);
        check(m_mode == 1'b0, "R9 mode unaffected", int'(m_mode), 0);
        repeat (30) @(negedge clk);
        check(m_starts == s0 + 1, "R9 single start", m_starts, s0 + 1);
        check(busy == 1'b0, "R9 idle after", int'(busy), 0);

        // R8: converter never finishes
        m_eoc_en = 1'b0;
        sample(1'b0, t);
        check(err == 1'b1 && valid == 1'b0, "R8 error pulse", int'({err, valid}), 2);
        check(t - m_second == CSW + TO, "R8 timeout delay", t - m_second, CSW + TO);
        @(negedge clk);
        check(err == 1'b0 && busy == 1'b0, "R8 back to idle", int'({err, busy}), 0);
        for (int k = 0; k < 20; k++) begin
            if (valid) break;
            @(negedge clk);
        end
        check(valid == 1'b0, "R8 no strobe after timeout", int'(valid), 0);
        m_eoc_en = 1'b1;

        // R5/R8: wake window applied after a timeout
        m_code = 14'h0ABC;
        sample(1'b0, t);
        check(m_win == CSW + WAKE, "R8 wake after timeout", m_win, CSW + WAKE);
        check(result == 14'h0ABC, "R7 result after timeout", int'(result), 'hABC);

        finish_run();
    end
endmodule